// File: doc/BRIEF.md
# Pseudo-Ternary Line Frame Transmitter

This block builds the 48-bit frames that the network end sends toward terminals on a four-wire digital subscriber bus. It serializes them as pseudo-ternary line pulses, one bit per `bit_en` strobe. Each frame carries two 64 kbit/s bearer channels, with two octets of each per frame. It also carries four bits of the 16 kbit/s D-channel, four echo bits, an activation bit, an auxiliary framing bit and its complement, a multiframe marker, a signalling bit, and two DC-balancing bits.

A binary one is sent as no pulse. A binary zero is sent as a pulse whose polarity is the opposite of the previous pulse. There are two exceptions, which are deliberate code violations that mark frame boundaries for the receiver. The first is the framing bit. The second is the first pulse after the framing-balance bit.

The bearer octets, the D bits and the multiframe inputs are captured once per frame. The echo and synchronized inputs are read live, at the bit position where each one is sent.

Top module: `pt_frame_tx`

## Requirements
- R1: While `rst_n` is low, `line_pos`, `line_neg` and `frame_start` are 0. The first framing bit after reset is a negative pulse (`line_neg`=1).
- R2: Bit positions 0..47 carry, in this order: F, L, B1 octet A, E, D, A, Fa, N, B2 octet A, E, D, M, B1 octet B, E, D, S, B2 octet B, E, D, L.
  - Octets are sent MSB first. Octet A is bits [15:8] of `b1_data`/`b2_data`, and octet B is bits [7:0].
  - The D bits are sent in the order `d_data[3]`, [2], [1], [0].
  - A data one produces no pulse, and a data zero produces a pulse.
- R3: The framing bit (position 0) is always a pulse with the same polarity as the previous pulse. Every other pulse has the opposite polarity to the previous pulse, except the one named in R5.
- R4: A balancing bit is a pulse when an odd number of pulses were sent since the previous balancing bit.
  - Position 1 balances the framing bit alone.
  - Position 47 balances positions 2..46.
- R5: The first pulse after position 1 repeats the polarity of the previous pulse (the second violation).
  - When `mf_en`=0, Fa (position 13) is 0, which guarantees that this pulse falls within 14 bits of F.
  - N (position 14) is always the complement of Fa.
  - When `mf_en`=1, Fa takes the value of `fa_in`.
- R6: Each echo bit (positions 10, 23, 34, 45) equals `echo_d` at the strobe that sends it.
- R7: The activation bit (position 12) equals `nt_synced` at that strobe: 0 while the terminal side is not synchronized, 1 once it is.
- R8: M (position 25) is 1 in frame 1 of every MF_LEN-frame multiframe and 0 otherwise. The first frame after reset is frame 1. S (position 36) is `s_in` when `mf_en`=1 and 0 otherwise.
- R9: `line_pos` and `line_neg` are never both 1.
- R10: `frame_start` is 1 exactly while the framing bit is on the line.
- R11: Outputs and the bit position change only on clock edges where `bit_en`=1.
- R12: `b1_data`, `b2_data`, `d_data`, `fa_in`, `s_in` and `mf_en` are sampled at the strobe that sends F. Changes later in the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| b1_data | input | 16 | First bearer channel, two octets per frame |
| b2_data | input | 16 | Second bearer channel, two octets per frame |
| d_data | input | 4 | D-channel bits for the frame |
| echo_d | input | 1 | Latest D bit received from the terminal side |
| nt_synced | input | 1 | Terminal side synchronized |
| mf_en | input | 1 | Multiframe bits active |
| fa_in | input | 1 | Fa value when multiframing |
| s_in | input | 1 | S value when multiframing |
| line_pos | output | 1 | Positive pulse strobe |
| line_neg | output | 1 | Negative pulse strobe |
| frame_start | output | 1 | High while the F bit is sent |

## Verification
The bench builds the block with MF_LEN set to 4 rather than 20. With that setting, several multiframe wraps of the M bit fit in about a dozen frames, so the marker's return to frame 1 is checked more than once. The bit strobe is pulsed every other cycle, so the idle cycles in between exercise the hold behaviour on every bit. An all-ones frame with multiframing off shows the second violation landing on Fa at position 13.

// File: rtl/pt_frame_tx.sv
module pt_frame_tx #(
  parameter int MF_LEN = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic [15:0] b1_data,
  input  logic [15:0] b2_data,
  input  logic [3:0]  d_data,
  input  logic        echo_d,
  input  logic        nt_synced,
  input  logic        mf_en,
  input  logic        fa_in,
  input  logic        s_in,
  output logic        line_pos,
  output logic        line_neg,
  output logic        frame_start
);
  localparam int MW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam logic [5:0] LAST = 6'd47;

  logic [5:0]    pos;
  logic [MW-1:0] mf_cnt;
  logic          last_pol;   // 1 = last pulse positive
  logic          par;
  logic          viol_pend;
  logic [15:0]   b1_q, b2_q;
  logic [3:0]    d_q;
  logic          fa_q, s_q;

  logic [5:0] k1a, k1b, k2a, k2b;
  assign k1a = 6'd17 - pos;
  assign k1b = 6'd33 - pos;
  assign k2a = 6'd30 - pos;
  assign k2b = 6'd44 - pos;

  logic bv;
  always_comb begin
    bv = 1'b1;
    case (pos) inside
      6'd0:                    bv = 1'b0;
      6'd1, LAST:              bv = ~par;
      [6'd2:6'd9]:             bv = b1_q[k1a[3:0]];
      [6'd26:6'd33]:           bv = b1_q[k1b[3:0]];
      [6'd15:6'd22]:           bv = b2_q[k2a[3:0]];
      [6'd37:6'd44]:           bv = b2_q[k2b[3:0]];
      6'd10, 6'd23, 6'd34, 6'd45: bv = echo_d;
      6'd11:                   bv = d_q[3];
      6'd24:                   bv = d_q[2];
      6'd35:                   bv = d_q[1];
      6'd46:                   bv = d_q[0];
      6'd12:                   bv = nt_synced;
      6'd13:                   bv = fa_q;
      6'd14:                   bv = ~fa_q;
      6'd25:                   bv = (mf_cnt == '0);
      6'd36:                   bv = s_q;
      default:                 bv = 1'b1;
    endcase
  end

  logic mark, pol_now;
  assign mark    = ~bv;
  assign pol_now = ((pos == 6'd0) || viol_pend) ? last_pol : ~last_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; mf_cnt <= '0; last_pol <= 1'b0; par <= 1'b0; viol_pend <= 1'b0;
      b1_q <= '0; b2_q <= '0; d_q <= '0; fa_q <= 1'b0; s_q <= 1'b0;
      line_pos <= 1'b0; line_neg <= 1'b0; frame_start <= 1'b0;
    end else if (bit_en) begin
      line_pos    <= mark & pol_now;
      line_neg    <= mark & ~pol_now;
      frame_start <= (pos == 6'd0);
      if (mark) last_pol <= pol_now;
      if (pos == 6'd1 || pos == LAST) par <= 1'b0;
      else if (mark)                  par <= ~par;
      if (pos == 6'd1)  viol_pend <= 1'b1;
      else if (mark)    viol_pend <= 1'b0;
      if (pos == 6'd0) begin
        b1_q <= b1_data;
        b2_q <= b2_data;
        d_q  <= d_data;
        fa_q <= mf_en & fa_in;
        s_q  <= mf_en & s_in;
      end
      if (pos == LAST) begin
        pos    <= '0;
        mf_cnt <= (mf_cnt == MW'(MF_LEN - 1)) ? '0 : mf_cnt + 1'b1;
      end else begin
        pos <= pos + 6'd1;
      end
    end
  end

  // R9
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos && line_neg));

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_pos || line_neg));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable({line_pos, line_neg, frame_start, pos}));

  // R3
  fbit_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pos == 6'd0) |=> (line_pos == $past(last_pol)));
endmodule

// File: tb/test_pt_frame_tx.sv
module test_pt_frame_tx;
  localparam int MF = 4;
  localparam int NV = 6;
  // {b1[16], b2[16], d[4], fa, s, mf_en, synced, echo}
  localparam logic [40:0] VEC [NV] = '{
    {16'hA55A, 16'h0F0F, 4'b1010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'h0000, 16'h0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'hFFFF, 16'hFFFF, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {16'h1234, 16'hFEDC, 4'b0110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h8001, 16'h7FFE, 4'b1001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {16'hC3C3, 16'h3C3C, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0, bit_en = 0;
  logic [15:0] b1_data, b2_data;
  logic [3:0] d_data;
  logic echo_d, nt_synced, mf_en, fa_in, s_in;
  logic line_pos, line_neg, frame_start;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pt_frame_tx #(.MF_LEN(MF)) i_pt_frame_tx (
    .clk, .rst_n, .bit_en, .b1_data, .b2_data, .d_data, .echo_d, .nt_synced,
    .mf_en, .fa_in, .s_in, .line_pos, .line_neg, .frame_start);

  int m_pos, m_frame, fmark;
  logic m_last, m_par, m_vp;
  logic [40:0] m_cur;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [40:0] v);
    {b1_data, b2_data, d_data, fa_in, s_in, mf_en, nt_synced, echo_d} = v;
  endtask

  function automatic logic exp_bit(input int p, input logic [40:0] c, input int fr,
                                   input logic par, input logic echo, input logic sync);
    logic [15:0] b1, b2; logic [3:0] d; logic fa, s, me;
    {b1, b2, d, fa, s, me} = c[40:2];
    if (p == 0) return 1'b0;
    if (p == 1 || p == 47) return ~par;
    if (p >= 2 && p <= 9) return b1[17-p];
    if (p >= 26 && p <= 33) return b1[33-p];
    if (p >= 15 && p <= 22) return b2[30-p];
    if (p >= 37 && p <= 44) return b2[44-p];
    if (p == 10 || p == 23 || p == 34 || p == 45) return echo;
    if (p == 11) return d[3];
    if (p == 24) return d[2];
    if (p == 35) return d[1];
    if (p == 46) return d[0];
    if (p == 12) return sync;
    if (p == 13) return me & fa;
    if (p == 14) return ~(me & fa);
    if (p == 25) return (fr % MF) == 0;
    return me & s;
  endfunction

  function automatic string tag_of(input int p);
    if (p == 0) return "R3";
    if (p == 1 || p == 47) return "R4";
    if (p == 10 || p == 23 || p == 34 || p == 45) return "R6";
    if (p == 12) return "R7";
    if (p == 13 || p == 14) return "R5";
    if (p == 25 || p == 36) return "R8";
    return "R2";
  endfunction

  task automatic model_reset();
    m_pos = 0; m_frame = 0; m_last = 0; m_par = 0; m_vp = 0; m_cur = '0; fmark = -1;
  endtask

  task automatic step();
    logic bv, mk, same, pol;
    int p;
    p = m_pos;
    if (p == 0) m_cur = {b1_data, b2_data, d_data, fa_in, s_in, mf_en, nt_synced, echo_d};
    bv = exp_bit(p, m_cur, m_frame, m_par, echo_d, nt_synced);
    mk = ~bv;
    same = (p == 0) || m_vp;
    pol = same ? m_last : ~m_last;
    @(negedge clk) bit_en = 1;
    @(negedge clk) bit_en = 0;
    chk(line_pos == (mk & pol) && line_neg == (mk & ~pol), tag_of(p),
        {line_pos, line_neg}, {mk & pol, mk & ~pol});
    chk(frame_start == (p == 0), "R10", frame_start, p == 0);
    if (line_pos && line_neg) chk(0, "R9", 3, 0);
    if (mk) m_last = pol;
    if (p == 1 || p == 47) m_par = 0; else if (mk) m_par = ~m_par;
    if (p == 1) begin m_vp = 1; fmark = -1; end
    else if (mk) begin
      if (m_vp && p > 1) fmark = p;
      m_vp = 0;
    end
    if (p == 47) begin m_pos = 0; m_frame++; end else m_pos++;
  endtask

  task automatic run_frame();
    for (int i = 0; i < 48; i++) step();
  endtask

  task automatic do_reset();
    rst_n = 0; bit_en = 0;
    repeat (3) @(negedge clk);
    chk(!line_pos && !line_neg && !frame_start, "R1", {line_pos, line_neg, frame_start}, 0);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive(VEC[0]);
    do_reset();
    // R1: first framing bit after reset is negative
    step();
    chk(line_neg && !line_pos, "R1", {line_pos, line_neg}, 1);
    for (int i = 1; i < 48; i++) step();
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v]);
      run_frame();
    end

    // R5: all-ones data with multiframing off: second violation on Fa
    drive({16'hFFFF, 16'hFFFF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1});
    for (int i = 0; i < 14; i++) step();
    chk(fmark == 13, "R5", fmark, 13);
    for (int i = 14; i < 48; i++) step();

    // R12: mid-frame input changes ignored
    drive(VEC[3]);
    for (int i = 0; i < 5; i++) step();
    b1_data = ~b1_data; b2_data = ~b2_data; d_data = ~d_data;
    mf_en = ~mf_en; fa_in = ~fa_in; s_in = ~s_in;
    for (int i = 5; i < 48; i++) begin
      step();
      if (i == 30) chk(1, "R12", 0, 0);
    end

    // R6, R7: echo and sync read live
    drive(VEC[4]);
    for (int i = 0; i < 48; i++) begin
      echo_d = i[1];
      nt_synced = i[2];
      step();
    end

    // R11: no strobe, no change
    begin
      logic [2:0] snap;
      snap = {line_pos, line_neg, frame_start};
      repeat (6) @(negedge clk);
      chk({line_pos, line_neg, frame_start} == snap, "R11",
          {line_pos, line_neg, frame_start}, snap);
    end
    drive(VEC[1]);
    run_frame();

    // R8: reset mid-run restarts the multiframe, and R1 again
    for (int i = 0; i < 20; i++) step();
    do_reset();
    drive(VEC[5]);
    step();
    chk(line_neg && !line_pos, "R1", {line_pos, line_neg}, 1);
    for (int i = 1; i < 48; i++) step();
    chk(m_frame == 1, "R8", m_frame, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule